// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Register

This block receives the control word for a transceiver's channel synthesizer. The word arrives over three wires: an active-low load strobe, a serial clock and a serial data line. Each frame carries sixteen bits. The first bit is a transmit-power selector. The next fifteen bits form the channel divide number, most significant bit first.

All three wires, plus the receive/transmit control line, pass through synchronizers into a faster system clock. Serial clock edges and strobe edges are detected in that clock domain. When the strobe is released after exactly sixteen bits from a well-formed start, the channel number goes straight to the active channel output. The power selector is parked in a pending slot and only takes effect when the next transmit burst starts.

Malformed frames are thrown away and raise a framing flag. Channel numbers that the downstream divider cannot divide correctly raise a range flag. A low level on the run input puts the block in standby and drops any half-received word.

Top module: `synth_prog_reg`

## Requirements
- R1: After reset the channel output is 3968, the power output is 0 (high power), and the pending, range and framing flags are all 0.
- R2: A frame is the data bits sampled at serial clock rising edges while the strobe is low. The first bit is the power selector; the next 15 bits give the channel number, most significant bit first. When the strobe rises after exactly 16 bits, the 15-bit channel output takes the new number within 4 system clocks.
- R3: Serial clock edges and data changes while the strobe is high leave every output unchanged.
- R4: If the strobe rises after any bit count other than 16, including 0 and more than 16, the outputs keep their previous channel and power values, pending is not set, and the framing flag goes to 1.
- R5: If the serial clock is low when the strobe falls, the frame is rejected even when it holds 16 bits: framing flag 1 and active values unchanged.
- R6: An accepted frame clears the framing flag to 0.
- R7: On an accepted frame the power selector (1 = low power, 0 = high power) does not reach the power output. Instead the pending flag goes to 1. The stored selector reaches the power output on the next high-to-low transition of the receive/transmit input (high = receive, low = transmit), and at that point pending returns to 0.
- R8: A low-to-high transition of the receive/transmit input, or a high-to-low transition with nothing pending, leaves the power output unchanged.
- R9: On an accepted frame the range flag is set to 1 if the channel number is below 3968 or above 32764, and cleared to 0 otherwise. The number is presented on the channel output in either case.
- R10: While the run input is low, a partial frame is discarded: the strobe rising afterwards commits nothing and leaves the framing flag as it was. A transmit start seen during standby does not apply the pending power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High for operation, low for standby |
| load_n_i | input | 1 | Serial strobe, active low |
| ser_clk_i | input | 1 | Serial clock, idles high |
| ser_dat_i | input | 1 | Serial data |
| rx_not_tx_i | input | 1 | High for receive, low for transmit |
| chan_div_o | output | 15 | Active channel divide number |
| tx_low_pwr_o | output | 1 | Active power selection, 1 = low power |
| pwr_pending_o | output | 1 | A power selection waits for the next transmit start |
| div_range_err_o | output | 1 | Last accepted channel number lies outside 3968..32764 |
| frame_err_o | output | 1 | Last completed frame was rejected |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 15-bit channel field, two synchronizer stages and the 3968..32764 divider window. With these values, every channel number next to both window edges is swept, together with the extreme codes and a walking-one set. Frame lengths from 0 to 20 bits are also swept, so each count other than 16 and the saturation of the bit counter are reached. Power selectors are carried through repeated receive/transmit toggles, with and without a pending value, and standby is entered both in the middle of a frame and during a transmit start.

// File: rtl/spr_pkg.sv
package spr_pkg;

    // Outcome of a frame, reported for one cycle when the strobe rises
    typedef enum logic [1:0] {
        FR_NONE = 2'd0,
        FR_GOOD = 2'd1,
        FR_BAD  = 2'd2
    } spr_frame_e;

endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{IDLE}};
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/spr_shifter.sv
module spr_shifter
    import spr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              load_n_s,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output spr_frame_e        result_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic              load_p;
        logic              sclk_p;
        logic              in_frame;
        logic              bad_start;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
    } shift_st_t;

    shift_st_t  st_d, st_q;
    spr_frame_e result_d;
    logic       load_fall, load_rise, sclk_rise;

    assign load_fall = st_q.load_p & ~load_n_s;
    assign load_rise = ~st_q.load_p & load_n_s;
    assign sclk_rise = ~st_q.sclk_p & sclk_s;

    always_comb begin
        st_d        = st_q;
        result_d    = FR_NONE;
        st_d.load_p = load_n_s;
        st_d.sclk_p = sclk_s;
        if (!run_i) begin
            st_d.in_frame  = 1'b0;
            st_d.bad_start = 1'b0;
            st_d.cnt       = '0;
        end else if (load_fall) begin
            st_d.in_frame  = 1'b1;
            st_d.bad_start = ~sclk_s;
            st_d.cnt       = '0;
        end else if (load_rise) begin
            if (st_q.in_frame) begin
                if (st_q.cnt == CNT_W'(WORD_W) && !st_q.bad_start) begin
                    result_d = FR_GOOD;
                end else begin
                    result_d = FR_BAD;
                end
            end
            st_d.in_frame = 1'b0;
        end else if (st_q.in_frame && !load_n_s && sclk_rise) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], sdat_s};
            if (st_q.cnt != CNT_W'(CNT_MAX)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{load_p: 1'b1, sclk_p: 1'b1, in_frame: 1'b0,
                      bad_start: 1'b0, cnt: '0, shreg: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = result_d;
    assign word_o   = st_q.shreg;

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(CNT_MAX));

    // R5
    bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && load_fall && !sclk_s) |=> st_q.bad_start);

    // R10
    standby_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !st_q.in_frame);

endmodule

// File: rtl/spr_apply.sv
module spr_apply
    import spr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CH_W   = 15,
    parameter int CH_MIN = 3968,
    parameter int CH_MAX = 32764
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  spr_frame_e        result_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              rxtx_s,
    output logic [CH_W-1:0]   chan_o,
    output logic              low_pwr_o,
    output logic              pending_o,
    output logic              range_err_o,
    output logic              frame_err_o
);

    localparam logic [CH_W-1:0] CH_LO = CH_W'(CH_MIN);
    localparam logic [CH_W-1:0] CH_HI = CH_W'(CH_MAX);

    typedef struct packed {
        logic            rxtx_p;
        logic [CH_W-1:0] chan;
        logic            low_pwr;
        logic            pend_val;
        logic            pend;
        logic            range_err;
        logic            frame_err;
    } apply_st_t;

    apply_st_t       st_d, st_q;
    logic            tx_start, good, new_oor;
    logic [CH_W-1:0] new_chan;

    assign tx_start = st_q.rxtx_p & ~rxtx_s;
    assign good     = run_i && (result_i == FR_GOOD);
    assign new_chan = word_i[CH_W-1:0];
    assign new_oor  = (new_chan < CH_LO) || (new_chan > CH_HI);

    always_comb begin
        st_d        = st_q;
        st_d.rxtx_p = rxtx_s;
        if (run_i) begin
            if (result_i == FR_GOOD) begin
                st_d.chan      = new_chan;
                st_d.pend_val  = word_i[WORD_W-1];
                st_d.pend      = 1'b1;
                st_d.range_err = new_oor;
                st_d.frame_err = 1'b0;
            end else if (result_i == FR_BAD) begin
                st_d.frame_err = 1'b1;
            end
            if (tx_start && st_q.pend && !good) begin
                st_d.low_pwr = st_q.pend_val;
                st_d.pend    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rxtx_p: 1'b1, chan: CH_LO, low_pwr: 1'b0, pend_val: 1'b0,
                      pend: 1'b0, range_err: 1'b0, frame_err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_o      = st_q.chan;
    assign low_pwr_o   = st_q.low_pwr;
    assign pending_o   = st_q.pend;
    assign range_err_o = st_q.range_err;
    assign frame_err_o = st_q.frame_err;

    // R2
    chan_only_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.chan) |-> $past(result_i == FR_GOOD));

    // R7
    pwr_only_on_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.low_pwr) |-> $past(tx_start && st_q.pend && run_i));

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tx_start && st_q.pend && result_i != FR_GOOD) |=> !st_q.pend);

    // R9
    range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && result_i == FR_GOOD) |=>
        (st_q.range_err == (($past(word_i[CH_W-1:0]) < CH_LO) ||
                            ($past(word_i[CH_W-1:0]) > CH_HI))));

endmodule

// File: rtl/synth_prog_reg.sv
module synth_prog_reg
    import spr_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CH_W        = WORD_W - 1,
    parameter int CH_MIN      = 3968,
    parameter int CH_MAX      = 32764,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            load_n_i,
    input  logic            ser_clk_i,
    input  logic            ser_dat_i,
    input  logic            rx_not_tx_i,
    output logic [CH_W-1:0] chan_div_o,
    output logic            tx_low_pwr_o,
    output logic            pwr_pending_o,
    output logic            div_range_err_o,
    output logic            frame_err_o
);

    localparam int         N_SYNC    = 4;
    localparam logic [3:0] SYNC_IDLE = 4'b1110;

    logic [N_SYNC-1:0] raw_in, synced;
    spr_frame_e        result;
    logic [WORD_W-1:0] word;

    assign raw_in = {rx_not_tx_i, load_n_i, ser_clk_i, ser_dat_i};

    spr_sync #(
        .W      (N_SYNC),
        .STAGES (SYNC_STAGES),
        .IDLE   (SYNC_IDLE)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (synced)
    );

    spr_shifter #(
        .WORD_W (WORD_W)
    ) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_i),
        .load_n_s (synced[2]),
        .sclk_s   (synced[1]),
        .sdat_s   (synced[0]),
        .result_o (result),
        .word_o   (word)
    );

    spr_apply #(
        .WORD_W (WORD_W),
        .CH_W   (CH_W),
        .CH_MIN (CH_MIN),
        .CH_MAX (CH_MAX)
    ) apply_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .result_i    (result),
        .word_i      (word),
        .rxtx_s      (synced[3]),
        .chan_o      (chan_div_o),
        .low_pwr_o   (tx_low_pwr_o),
        .pending_o   (pwr_pending_o),
        .range_err_o (div_range_err_o),
        .frame_err_o (frame_err_o)
    );

    // R6
    good_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && result == FR_GOOD) |=> !frame_err_o);

    // R4
    bad_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && result == FR_BAD) |=> (frame_err_o && $stable(chan_div_o)));

endmodule

// File: tb/synth_prog_reg_tb_top.sv
module synth_prog_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b1;
    logic        load_n_i = 1'b1;
    logic        ser_clk_i = 1'b1;
    logic        ser_dat_i = 1'b0;
    logic        rx_not_tx_i = 1'b1;
    logic [14:0] chan_div_o;
    logic        tx_low_pwr_o, pwr_pending_o, div_range_err_o, frame_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [14:0] e_chan  = 15'd3968;
    logic        e_low   = 1'b0;
    logic        e_pval  = 1'b0;
    logic        e_pend  = 1'b0;
    logic        e_rerr  = 1'b0;
    logic        e_ferr  = 1'b0;

    always #4 clk = ~clk;

    synth_prog_reg dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .run_i           (run_i),
        .load_n_i        (load_n_i),
        .ser_clk_i       (ser_clk_i),
        .ser_dat_i       (ser_dat_i),
        .rx_not_tx_i     (rx_not_tx_i),
        .chan_div_o      (chan_div_o),
        .tx_low_pwr_o    (tx_low_pwr_o),
        .pwr_pending_o   (pwr_pending_o),
        .div_range_err_o (div_range_err_o),
        .frame_err_o     (frame_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(chan_div_o == e_chan, {req, " chan"}, chan_div_o, e_chan);
        chk(tx_low_pwr_o == e_low, {req, " lowpwr"}, tx_low_pwr_o, e_low);
        chk(pwr_pending_o == e_pend, {req, " pending"}, pwr_pending_o, e_pend);
        chk(div_range_err_o == e_rerr, {req, " range"}, div_range_err_o, e_rerr);
        chk(frame_err_o == e_ferr, {req, " frame"}, frame_err_o, e_ferr);
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_clk_i = 1'b0;
        ser_dat_i = b;
        wclk(4);
        ser_clk_i = 1'b1;
        wclk(4);
    endtask

    function automatic void model_commit(input logic [15:0] w);
        e_chan = w[14:0];
        e_pval = w[15];
        e_pend = 1'b1;
        e_rerr = (w[14:0] < 15'd3968) || (w[14:0] > 15'd32764);
        e_ferr = 1'b0;
    endfunction

    // Sends nbits of w, first bit first; bad_start drops the clock before the strobe
    task automatic send_frame(input logic [15:0] w, input int nbits, input bit bad_start);
        if (bad_start) begin
            ser_clk_i = 1'b0;
            wclk(4);
        end
        load_n_i = 1'b0;
        wclk(4);
        for (int i = 0; i < nbits; i++) begin
            shift_bit(w[(15 - i) & 15]);
        end
        ser_clk_i = 1'b1;
        wclk(4);
        load_n_i = 1'b1;
        wclk(5);
        if (nbits == 16 && !bad_start) model_commit(w);
        else e_ferr = 1'b1;
    endtask

    task automatic tx_burst();
        rx_not_tx_i = 1'b0;
        wclk(5);
        if (e_pend) begin
            e_low  = e_pval;
            e_pend = 1'b0;
        end
    endtask

    task automatic rx_back();
        rx_not_tx_i = 1'b1;
        wclk(5);
    endtask

    initial begin
        wclk(3);
        rst_n = 1'b1;
        wclk(3);
        // R1 reset state
        check_all("R1");

        // R2 / R9 sweep around both divider window edges
        for (int v = 3958; v <= 3978; v++) begin
            send_frame({1'b0, 15'(v)}, 16, 1'b0);
            check_all("R2/R9 low edge");
        end
        for (int v = 32754; v <= 32767; v++) begin
            send_frame({1'b0, 15'(v)}, 16, 1'b0);
            check_all("R2/R9 high edge");
        end
        send_frame(16'h0000, 16, 1'b0);
        check_all("R9 zero");
        for (int b = 0; b < 15; b++) begin
            send_frame(16'(1 << b), 16, 1'b0);
            check_all("R2 walking one");
        end

        // R7 deferred power: pending after commit, applied at transmit start
        send_frame({1'b1, 15'd14313}, 16, 1'b0);
        check_all("R7 held back");
        rx_back();
        tx_burst();
        check_all("R7 applied");
        // R8 back to receive, then transmit start with nothing pending
        rx_back();
        check_all("R8 rise");
        tx_burst();
        check_all("R8 no pending");
        rx_back();
        send_frame({1'b0, 15'd5000}, 16, 1'b0);
        tx_burst();
        check_all("R7 back to high");
        rx_back();

        // R3 serial clock activity with strobe high
        for (int i = 0; i < 20; i++) begin
            ser_dat_i = i[0];
            ser_clk_i = 1'b0;
            wclk(3);
            ser_clk_i = 1'b1;
            wclk(3);
        end
        wclk(4);
        check_all("R3 idle clocks");

        // R4 / R6 frame length sweep
        for (int n = 0; n <= 20; n++) begin
            if (n != 16) begin
                send_frame(16'hFFFF, n, 1'b0);
                check_all("R4 length");
                send_frame({1'b0, 15'(4000 + n)}, 16, 1'b0);
                check_all("R6 recovery");
            end
        end

        // R5 serial clock low at strobe fall
        send_frame({1'b1, 15'd20000}, 16, 1'b1);
        check_all("R5 bad start");
        send_frame({1'b1, 15'd20001}, 16, 1'b0);
        check_all("R6 after bad start");

        // R10 standby in mid-frame
        load_n_i = 1'b0;
        wclk(4);
        for (int i = 0; i < 8; i++) shift_bit(1'b0);
        run_i = 1'b0;
        wclk(6);
        run_i = 1'b1;
        wclk(4);
        for (int i = 0; i < 8; i++) shift_bit(1'b1);
        load_n_i = 1'b1;
        wclk(5);
        check_all("R10 discarded");
        // R10 transmit start during standby does not apply pending
        run_i = 1'b0;
        wclk(2);
        rx_not_tx_i = 1'b0;
        wclk(6);
        check_all("R10 tx in standby");
        run_i = 1'b1;
        wclk(2);
        rx_back();
        tx_burst();
        check_all("R10 tx after wake");
        rx_back();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule